// File: doc/BRIEF.md
# Dual-Buffer Ethernet Transmit Sequencer

This block is the transmit half of a small memory-mapped Ethernet MAC. Software fills one of two frame buffers through a 32-bit register port. It then writes that buffer's length word and its control word. A single control write does one of two things. It either sends the buffer contents as a frame on a byte-wide valid/ready stream, or it loads the 48-bit station address from the first six bytes of the buffer. The command bits clear themselves, so software never sees them set.

A frame may be started while the other buffer is still being sent. The command is held as a pending bit for its buffer and starts once the current frame's last byte has been handed off. When an action finishes, the block can raise a one-cycle interrupt pulse. This happens only if the buffer's enable bit and the global enable bit are both set. Preamble, frame check sequence, the PHY and the receive side belong to other blocks.

The stream follows the usual valid/ready rules. A beat transfers on a rising edge where both `m_tvalid` and `m_tready` are high. While `m_tready` is low, the block holds `m_tvalid`, `m_tdata` and `m_tlast` unchanged, and it never withdraws a beat it has offered. `m_tvalid` does not depend on `m_tready`.

Top module: `ethtx_seq`

## Requirements
- R1: Registers are addressed by word index (byte offset divided by 4), and every access is one 32-bit word. Buffer 0 covers byte offsets 0x000-0x7FF and buffer 1 covers 0x800-0xFFF. In each buffer, the data words lie below offset +0x7F4, the length word is at +0x7F4 and the control word is at +0x7FC. The global enable is at 0x7F8. Data words, the global enable and the low 11 bits of each length word read back as written. The upper length bits read as zero. Offset 0xFF8 reads as zero and ignores writes. Read data appears on `reg_rdata` after the rising edge that samples `reg_rd_en`.
- R2: In the control word, bit 0 is the start bit, bit 1 is the address-load bit and bit 3 is the interrupt-enable bit. Bits 0 and 1 always read back as zero, and every other written bit is kept. A control write with bit 0 clear starts nothing.
- R3: A control write with bit 0 set and bit 1 clear sends that buffer's length (bits 10:0 of its length word) in bytes on the stream. Frame byte k comes from bits [8*(k mod 4)+7 : 8*(k mod 4)] of data word k/4. The first beat is offered after the edge that follows the accepting edge. `m_tlast` marks the final byte only.
- R4: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` stay unchanged.
- R5: A control write with bits 0 and 1 both set loads `station_addr` from the buffer's first six bytes. Byte 0 goes to bits 47:40 and byte 5 goes to bits 7:0. The new value is visible after the accepting edge, and no beat is sent. `station_addr` changes on no other event.
- R6: `irq_pulse` is high for one cycle when an action completes, and only if bit 31 of the global enable is set. A frame completion raises it after the edge of the tlast handshake (or after the launch edge for an empty frame), gated by the buffer's stored control bit 3. An address load raises it after the accepting edge, gated by bit 3 of the word being written.
- R7: `tx_busy` is high from the edge that accepts a start until the edge that hands off the last byte of the last queued frame.
- R8: A start that arrives while a frame is streaming is held as a pending bit for its buffer. It begins after the current frame ends. A second start for a buffer that is already pending merges into one frame. When both buffers are pending, the buffer other than the one sent last goes first.
- R9: A length of zero completes in the cycle after the start is accepted, with no beat. It still raises the interrupt when enabled.
- R10: After reset, `m_tvalid`, `tx_busy` and `irq_pulse` are low. The length words, the control words and the global enable read as zero, and `station_addr` equals the `STATION_RST` parameter (default 48'h020000000001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_waddr | input | 10 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| m_tdata | output | 8 | Frame byte |
| m_tvalid | output | 1 | Frame byte offered |
| m_tready | input | 1 | Sink accepts byte |
| m_tlast | output | 1 | Final byte of frame |
| tx_busy | output | 1 | Frame streaming or pending |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| station_addr | output | 48 | Station MAC address |

## Verification
Each result has a fixed latency from the stimulus that causes it:
- Register read data, the station address and an address-load interrupt appear one edge after the access.
- The first beat of a frame, and the interrupt for an empty frame, appear two edges after the control write.
- A frame-completion interrupt and the drop of `tx_busy` appear one edge after the tlast handshake.

The bench drives all inputs on falling edges and samples at the falling edge that follows the edge where each result is due. It decides handshakes from the `m_tvalid` and `m_tready` it sees at the falling edge before the transfer. During stalls it compares the held beat against the value recorded one cycle earlier.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;
  localparam int NBUF   = 2;
  localparam int BUF_W  = 1;
  localparam int CTL_START = 0;
  localparam int CTL_PROG  = 1;
  localparam int CTL_IE    = 3;
  localparam int GIE_BIT   = 31;
  localparam logic [31:0] CTL_SELF_CLR = 32'h0000_0003;

  typedef struct packed {
    logic start;
    logic prog;
    logic ie;
  } ctl_cmd_t;

  function automatic logic [7:0] lane_pick(input logic [31:0] w, input logic [1:0] l);
    return w[{l, 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/ethtx_regs.sv
module ethtx_regs
  import ethtx_pkg::*;
#(
  parameter int BUF_WORDS = 512,
  localparam int WIDX_W = $clog2(BUF_WORDS),
  localparam int WA_W   = WIDX_W + 1,
  localparam int LEN_W  = WIDX_W + 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [WA_W-1:0]              waddr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  output logic [NBUF-1:0][LEN_W-1:0]   len_all,
  output logic [NBUF-1:0]              ie_all,
  output logic                         gie_en,
  output logic                         ctl_wr,
  output logic [BUF_W-1:0]             ctl_buf,
  output ctl_cmd_t                     ctl_cmd,
  output logic [47:0]                  head_addr,
  input  logic [BUF_W-1:0]             rd_buf,
  input  logic [LEN_W-1:0]             rd_idx,
  output logic [7:0]                   rd_byte
);
  localparam logic [WIDX_W-1:0] LEN_SLOT = WIDX_W'(BUF_WORDS - 3);
  localparam logic [WIDX_W-1:0] GIE_SLOT = WIDX_W'(BUF_WORDS - 2);
  localparam logic [WIDX_W-1:0] CTL_SLOT = WIDX_W'(BUF_WORDS - 1);

  logic [BUF_W-1:0]  bsel;
  logic [WIDX_W-1:0] slot;
  logic              is_data;
  logic [31:0]       mem [NBUF][BUF_WORDS];
  logic [31:0]       gie_q;
  logic [NBUF-1:0][31:0] ctl_all;

  assign bsel    = waddr[WA_W-1];
  assign slot    = waddr[WIDX_W-1:0];
  assign is_data = (slot < LEN_SLOT);

  // frame storage: plain words, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en && is_data) mem[bsel][slot] <= wdata;
  end

  // per-buffer length and control words
  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic [LEN_W-1:0] len_r;
    logic [31:0]      ctl_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_r <= '0;
        ctl_r <= '0;
      end else if (wr_en && (bsel == BUF_W'(g))) begin
        if (slot == LEN_SLOT) len_r <= wdata[LEN_W-1:0];
        if (slot == CTL_SLOT) ctl_r <= wdata & ~CTL_SELF_CLR;
      end
    end
    assign len_all[g] = len_r;
    assign ctl_all[g] = ctl_r;
    assign ie_all[g]  = ctl_r[CTL_IE];
  end

  // global enable exists only beside buffer 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       gie_q <= '0;
    else if (wr_en && bsel == '0 && slot == GIE_SLOT) gie_q <= wdata;
  end
  assign gie_en = gie_q[GIE_BIT];

  // command strobe towards the decoder
  always_comb begin
    ctl_wr        = wr_en && (slot == CTL_SLOT);
    ctl_buf       = bsel;
    ctl_cmd.start = wdata[CTL_START];
    ctl_cmd.prog  = wdata[CTL_PROG];
    ctl_cmd.ie    = wdata[CTL_IE];
  end

  // first six bytes of the addressed buffer, byte 0 most significant
  assign head_addr = {mem[bsel][0][7:0],  mem[bsel][0][15:8],
                      mem[bsel][0][23:16], mem[bsel][0][31:24],
                      mem[bsel][1][7:0],  mem[bsel][1][15:8]};

  // byte port for the stream engine
  assign rd_byte = lane_pick(mem[rd_buf][rd_idx[LEN_W-1:2]], rd_idx[1:0]);

  // registered readback
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (slot == LEN_SLOT)      rdata <= 32'(len_all[bsel]);
      else if (slot == GIE_SLOT) rdata <= (bsel == '0) ? gie_q : '0;
      else if (slot == CTL_SLOT) rdata <= ctl_all[bsel];
      else                       rdata <= mem[bsel][slot];
    end
  end
endmodule

// File: rtl/ethtx_cmd.sv
module ethtx_cmd
  import ethtx_pkg::*;
#(
  parameter logic [47:0] STATION_RST = 48'h02_00_00_00_00_01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [BUF_W-1:0]  ctl_buf,
  input  ctl_cmd_t          ctl_cmd,
  input  logic [47:0]       head_addr,
  input  logic              take,
  input  logic [BUF_W-1:0]  take_buf,
  input  logic              done_evt,
  input  logic [BUF_W-1:0]  done_buf,
  input  logic [NBUF-1:0]   ie_all,
  input  logic              gie_en,
  output logic [NBUF-1:0]   pend,
  output logic [47:0]       station_addr,
  output logic              irq_pulse
);
  logic            send_req;
  logic            load_req;
  logic [NBUF-1:0] pend_n;
  logic            irq_n;

  assign send_req = ctl_wr && ctl_cmd.start && !ctl_cmd.prog;
  assign load_req = ctl_wr && ctl_cmd.start &&  ctl_cmd.prog;

  // a new start on a buffer wins over its clear in the same cycle
  always_comb begin
    pend_n = pend;
    if (take)     pend_n[take_buf] = 1'b0;
    if (send_req) pend_n[ctl_buf]  = 1'b1;
  end

  assign irq_n = gie_en && ((load_req && ctl_cmd.ie) ||
                            (done_evt && ie_all[done_buf]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend         <= '0;
      station_addr <= STATION_RST;
      irq_pulse    <= 1'b0;
    end else begin
      pend      <= pend_n;
      irq_pulse <= irq_n;
      if (load_req) station_addr <= head_addr;
    end
  end
endmodule

// File: rtl/ethtx_stream.sv
module ethtx_stream
  import ethtx_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NBUF-1:0]             pend,
  input  logic [NBUF-1:0][LEN_W-1:0]  len_all,
  output logic                        take,
  output logic [BUF_W-1:0]            take_buf,
  output logic [BUF_W-1:0]            rd_buf,
  output logic [LEN_W-1:0]            rd_idx,
  input  logic [7:0]                  rd_byte,
  output logic [7:0]                  m_tdata,
  output logic                        m_tvalid,
  input  logic                        m_tready,
  output logic                        m_tlast,
  output logic                        done_evt,
  output logic [BUF_W-1:0]            done_buf
);
  logic [BUF_W-1:0] cur_buf;
  logic [BUF_W-1:0] last_buf;
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] take_len;
  logic             hs;

  // both pending: serve the buffer not sent last
  always_comb begin
    take_buf = (pend == 2'b11) ? ~last_buf : BUF_W'(pend[1]);
    take     = !m_tvalid && (|pend);
    take_len = len_all[take_buf];
    hs       = m_tvalid && m_tready;
    rd_buf   = m_tvalid ? cur_buf : take_buf;
    rd_idx   = m_tvalid ? idx : '0;
    done_evt = (hs && m_tlast) || (take && take_len == '0);
    done_buf = m_tvalid ? cur_buf : take_buf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_buf  <= '0;
      last_buf <= '1;
      cur_len  <= '0;
      idx      <= '0;
      m_tdata  <= '0;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
    end else if (take) begin
      cur_buf  <= take_buf;
      last_buf <= take_buf;
      cur_len  <= take_len;
      if (take_len != '0) begin
        m_tvalid <= 1'b1;
        m_tdata  <= rd_byte;
        m_tlast  <= (take_len == LEN_W'(1));
        idx      <= LEN_W'(1);
      end
    end else if (hs) begin
      if (m_tlast) begin
        m_tvalid <= 1'b0;
        m_tlast  <= 1'b0;
      end else begin
        m_tdata <= rd_byte;
        m_tlast <= (idx == cur_len - LEN_W'(1));
        idx     <= idx + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/ethtx_seq.sv
module ethtx_seq
  import ethtx_pkg::*;
#(
  parameter int          BUF_WORDS   = 512,
  parameter logic [47:0] STATION_RST = 48'h02_00_00_00_00_01,
  localparam int WIDX_W = $clog2(BUF_WORDS),
  localparam int WA_W   = WIDX_W + 1,
  localparam int LEN_W  = WIDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [WA_W-1:0]  reg_waddr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [7:0]       m_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic             m_tlast,
  output logic             tx_busy,
  output logic             irq_pulse,
  output logic [47:0]      station_addr
);
  logic [NBUF-1:0][LEN_W-1:0] len_all;
  logic [NBUF-1:0]            ie_all;
  logic                       gie_en;
  logic                       ctl_wr;
  logic [BUF_W-1:0]           ctl_buf;
  ctl_cmd_t                   ctl_cmd;
  logic [47:0]                head_addr;
  logic [BUF_W-1:0]           rd_buf;
  logic [LEN_W-1:0]           rd_idx;
  logic [7:0]                 rd_byte;
  logic [NBUF-1:0]            pend;
  logic                       take;
  logic [BUF_W-1:0]           take_buf;
  logic                       done_evt;
  logic [BUF_W-1:0]           done_buf;

  ethtx_regs #(.BUF_WORDS(BUF_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .waddr(reg_waddr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .len_all(len_all), .ie_all(ie_all), .gie_en(gie_en),
    .ctl_wr(ctl_wr), .ctl_buf(ctl_buf), .ctl_cmd(ctl_cmd),
    .head_addr(head_addr),
    .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  ethtx_cmd #(.STATION_RST(STATION_RST)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_buf(ctl_buf), .ctl_cmd(ctl_cmd),
    .head_addr(head_addr),
    .take(take), .take_buf(take_buf),
    .done_evt(done_evt), .done_buf(done_buf),
    .ie_all(ie_all), .gie_en(gie_en),
    .pend(pend), .station_addr(station_addr), .irq_pulse(irq_pulse)
  );

  ethtx_stream #(.LEN_W(LEN_W)) u_stream (
    .clk(clk), .rst_n(rst_n),
    .pend(pend), .len_all(len_all),
    .take(take), .take_buf(take_buf),
    .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_byte(rd_byte),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast),
    .done_evt(done_evt), .done_buf(done_buf)
  );

  assign tx_busy = m_tvalid || (|pend);
endmodule

// File: rtl/ethtx_seq_chk.sv
module ethtx_seq_chk #(
  parameter int WA_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_en,
  input logic            reg_rd_en,
  input logic [WA_W-1:0] reg_waddr,
  input logic [31:0]     reg_rdata,
  input logic [7:0]      m_tdata,
  input logic            m_tvalid,
  input logic            m_tready,
  input logic            m_tlast,
  input logic            tx_busy,
  input logic            irq_pulse,
  input logic [47:0]     station_addr,
  input logic            gie_en
);
  logic ctl_slot;
  assign ctl_slot = &reg_waddr[WA_W-2:0];

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R4
  AST_STATION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && ctl_slot) |=> $stable(station_addr)); // R5
  AST_CMD_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && ctl_slot) |=> (reg_rdata[1:0] == 2'b00)); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(gie_en)); // R6
  AST_BUSY_COVERS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> tx_busy); // R7
endmodule

bind ethtx_seq ethtx_seq_chk #(.WA_W(WA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_waddr(reg_waddr), .reg_rdata(reg_rdata), .m_tdata(m_tdata),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
  .tx_busy(tx_busy), .irq_pulse(irq_pulse), .station_addr(station_addr),
  .gie_en(gie_en)
);

// File: tb/sim_ethtx_seq.sv
module sim_ethtx_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] LEN_OFF = 12'h7F4;
  localparam logic [11:0] GIE_OFF = 12'h7F8;
  localparam logic [11:0] CTL_OFF = 12'h7FC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [9:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b0;
  logic        m_tlast;
  logic        tx_busy;
  logic        irq_pulse;
  logic [47:0] station_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit summary_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ethtx_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .tx_busy(tx_busy), .irq_pulse(irq_pulse),
    .station_addr(station_addr)
  );

  typedef struct packed {
    logic        bsel;
    logic [10:0] len;
    logic        ie;
    logic        gie;
    logic [2:0]  stall;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b0, 11'd1,  1'b1, 1'b1, 3'd0, 8'h03},
    '{1'b1, 11'd7,  1'b1, 1'b1, 3'd2, 8'h40},
    '{1'b0, 11'd12, 1'b0, 1'b1, 3'd3, 8'h11},
    '{1'b1, 11'd4,  1'b1, 1'b0, 3'd0, 8'h99},
    '{1'b0, 11'd33, 1'b1, 1'b1, 3'd4, 8'h5A}
  };

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int k, input int s);
    return 8'(k * 13 + b * 91 + s);
  endfunction

  task automatic reg_wr(input logic [11:0] boff, input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_waddr = boff[11:2];
    reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] boff, output logic [31:0] v);
    @(negedge clk);
    reg_rd_en = 1'b1;
    reg_waddr = boff[11:2];
    @(negedge clk);
    reg_rd_en = 1'b0;
    v = reg_rdata;
  endtask

  task automatic fill(input int b, input int n, input int s);
    for (int w = 0; w < (n + 3) / 4; w++)
      reg_wr(12'(b * 2048 + w * 4),
             {pat(b, 4*w+3, s), pat(b, 4*w+2, s), pat(b, 4*w+1, s), pat(b, 4*w, s)});
  endtask

  // collects n beats of buffer b; tready low one cycle out of every 'stall'
  task automatic collect(input int b, input int n, input int s, input int stall);
    int got = 0;
    int c = 0;
    bit held = 0;
    logic [7:0] held_d = '0;
    while (got < n && c < 2000) begin
      @(negedge clk);
      if (held) check(m_tvalid && m_tdata == held_d, "R4 stalled beat held", {m_tvalid, m_tdata}, {1'b1, held_d});
      m_tready = (stall == 0) ? 1'b1 : ((c % stall) != 0);
      held = 0;
      if (m_tvalid && !m_tready) begin
        held = 1;
        held_d = m_tdata;
      end
      if (m_tvalid && m_tready) begin
        check(m_tdata == pat(b, got, s), "R3 frame byte", m_tdata, pat(b, got, s));
        check(m_tlast == (got == n - 1), "R3 tlast position", m_tlast, (got == n - 1));
        got++;
      end
      c++;
    end
    check(got == n, "R3 beat count", got, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R0 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(!m_tvalid && !tx_busy && !irq_pulse, "R10 outputs idle", {m_tvalid, tx_busy, irq_pulse}, 0);
    check(station_addr == 48'h020000000001, "R10 station default", station_addr, 48'h020000000001);
    reg_rd(CTL_OFF, v); check(v == 0, "R10 ctrl0 zero", v, 0);
    reg_rd(12'h800 + LEN_OFF, v); check(v == 0, "R10 len1 zero", v, 0);
    reg_rd(GIE_OFF, v); check(v == 0, "R10 gie zero", v, 0);

    // readback map
    reg_wr(12'h814, 32'hCAFE_0123);
    reg_rd(12'h814, v); check(v == 32'hCAFE_0123, "R1 data word readback", v, 32'hCAFE_0123);
    reg_wr(12'h800 + LEN_OFF, 32'hFFFF_F923);
    reg_rd(12'h800 + LEN_OFF, v); check(v == 32'h0000_0123, "R1 length low bits", v, 32'h123);
    reg_wr(12'hFF8, 32'hFFFF_FFFF);
    reg_rd(12'hFF8, v); check(v == 0, "R1 0xFF8 reads zero", v, 0);
    reg_wr(GIE_OFF, 32'h8000_0055);
    reg_rd(GIE_OFF, v); check(v == 32'h8000_0055, "R1 gie readback", v, 32'h8000_0055);
    reg_wr(CTL_OFF, 32'h0000_00F8);
    check(!tx_busy, "R2 no start without bit0", tx_busy, 0);
    reg_rd(CTL_OFF, v); check(v == 32'hF8, "R2 ctrl retains upper bits", v, 32'hF8);
    check(!m_tvalid, "R2 no beat without bit0", m_tvalid, 0);

    // table of frames
    for (int i = 0; i < 5; i++) begin
      vec_t t = VEC[i];
      int b = int'(t.bsel);
      m_tready = 1'b0;
      fill(b, int'(t.len), int'(t.seed));
      reg_wr(12'(b * 2048) + LEN_OFF, 32'(t.len));
      reg_wr(GIE_OFF, t.gie ? 32'h8000_0000 : 32'h0);
      reg_wr(12'(b * 2048) + CTL_OFF, {28'h0, t.ie, 3'b001});
      check(tx_busy && !m_tvalid, "R7 busy after accept, beat next", {tx_busy, m_tvalid}, 2'b10);
      collect(b, int'(t.len), int'(t.seed), int'(t.stall));
      @(negedge clk);
      m_tready = 1'b0;
      check(irq_pulse == (t.ie && t.gie), "R6 completion interrupt", irq_pulse, (t.ie && t.gie));
      check(!tx_busy, "R7 busy clear after last", tx_busy, 0);
      reg_rd(12'(b * 2048) + CTL_OFF, v);
      check(v == {28'h0, t.ie, 3'b000}, "R2 start bit self-clears", v, {28'h0, t.ie, 3'b000});
    end

    // station address load
    reg_wr(12'h800, 32'h4433_2211);
    reg_wr(12'h804, 32'hAAAA_6655);
    reg_wr(GIE_OFF, 32'h8000_0000);
    reg_wr(12'h800 + CTL_OFF, 32'h0000_000B);
    check(station_addr == 48'h112233445566, "R5 station loaded", station_addr, 48'h112233445566);
    check(irq_pulse, "R6 load interrupt", irq_pulse, 1);
    check(!tx_busy, "R5 no frame queued", tx_busy, 0);
    @(negedge clk);
    check(!m_tvalid, "R5 no beat", m_tvalid, 0);
    reg_rd(12'h800 + CTL_OFF, v); check(v == 32'h8, "R2 both command bits clear", v, 32'h8);

    // zero length
    reg_wr(LEN_OFF, 32'h0);
    reg_wr(CTL_OFF, 32'h0000_0009);
    check(tx_busy && !irq_pulse, "R9 pending, no interrupt yet", {tx_busy, irq_pulse}, 2'b10);
    @(negedge clk);
    check(irq_pulse && !m_tvalid && !tx_busy, "R9 immediate completion", {irq_pulse, m_tvalid, tx_busy}, 3'b100);

    // start while streaming
    m_tready = 1'b0;
    reg_wr(GIE_OFF, 32'h0);
    fill(0, 5, 8'h21);
    fill(1, 3, 8'h70);
    reg_wr(LEN_OFF, 32'd5);
    reg_wr(12'h800 + LEN_OFF, 32'd3);
    reg_wr(CTL_OFF, 32'h1);
    @(negedge clk);
    check(m_tvalid && m_tdata == pat(0, 0, 8'h21), "R8 first frame started", m_tdata, pat(0, 0, 8'h21));
    reg_wr(12'h800 + CTL_OFF, 32'h1);
    reg_wr(12'h800 + CTL_OFF, 32'h1);
    check(tx_busy, "R8 busy while queued", tx_busy, 1);
    collect(0, 5, 8'h21, 0);
    collect(1, 3, 8'h70, 2);
    @(negedge clk);
    m_tready = 1'b0;
    repeat (3) @(negedge clk);
    check(!tx_busy && !m_tvalid, "R8 merged start sent once", {tx_busy, m_tvalid}, 0);

    summary();
    $finish;
  end
endmodule